// File: doc/BRIEF.md
# Single-Precision Floating-Point Compare Unit

This block compares two IEEE 754 single-precision operands and condenses the outcome into a four-bit condition group {N, Z, C, V}. Later conditional logic can test that group. Each request chooses between a quiet compare and a signaling compare. A request can also compare the first operand with positive zero instead of the second operand.

When either operand is a NaN, the compare is unordered and produces its own flag code. A sticky invalid-operation flag records the compares that the IEEE rules treat as invalid. It stays set until it is cleared explicitly. The flags register one clock after a request, and a one-cycle strobe marks every update.

Top module: `fp_cmp_unit`

## Requirements
- R1: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are not all zero. Bit 22 set marks a quiet NaN and bit 22 clear marks a signaling NaN.
- R2: When either compared operand is a NaN, the flags (flags_o[3]=N, [2]=Z, [1]=C, [0]=V) become 4'b0011 (unordered).
- R3: For ordered operands the flags are 4'b1000 when A is less than B, 4'b0110 when they are equal, and 4'b0010 when A is greater than B.
- R4: Positive and negative zero compare equal. An infinity orders by sign against finite values and is equal to an infinity of the same sign. Two negative values order by inverted magnitude.
- R5: A quiet compare (req_signaling=0) sets invalid_o for a signaling NaN operand, and leaves it unchanged for quiet NaN operands.
- R6: A signaling compare (req_signaling=1) sets invalid_o for any NaN operand.
- R7: With req_zero_b=1, A is compared with +0.0 and op_b has no effect on the flags or on invalid_o.
- R8: flags_o and flags_vld_o update at the clock edge that samples req_valid. flags_vld_o is high for exactly that one cycle, and flags_o holds when there is no request.
- R9: invalid_o stays set until clr_invalid is sampled high. If a new invalid compare arrives in the same cycle as a clear, the flag stays set.
- R10: After reset flags_o is 4'b0000, and flags_vld_o and invalid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Compare request |
| req_signaling | input | 1 | 1: signaling compare, 0: quiet compare |
| req_zero_b | input | 1 | 1: compare op_a with +0.0 |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| clr_invalid | input | 1 | Clear the sticky invalid flag |
| flags_o | output | 4 | N, Z, C, V condition group |
| flags_vld_o | output | 1 | Flags updated this cycle |
| invalid_o | output | 1 | Sticky invalid-operation flag |

## Verification
The assertions assume that req_valid, req_signaling, req_zero_b and clr_invalid are always known after reset. They also assume that the operands are known whenever a request is sampled, because the checker works out the NaN kind of each operand again from the ports. The stimulus changes every input only on the falling clock edge and drives defined values at all times, including idle cycles. Random operands are taken from NaN, infinity, zero and finite classes, so every class appears under both compare variants and with the zero substitution.

// File: rtl/fpc_pkg.sv
// Package: shared widths, flag codes and operand class type for the compare unit.
package fpc_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;

    // Condition codes, bit order {N, Z, C, V}
    typedef enum logic [3:0] {
        CC_NONE = 4'b0000,
        CC_LT   = 4'b1000,
        CC_EQ   = 4'b0110,
        CC_GT   = 4'b0010,
        CC_UN   = 4'b0011
    } cc_e;

    typedef struct packed {
        logic nan;
        logic snan;
        logic zero;
        logic inf;
    } fp_class_t;
endpackage

// File: rtl/fpc_classify.sv
// Module: fpc_classify
// Sorts one operand into NaN (quiet/signaling), zero and infinity classes.
// Assumes the exponent field lies directly above the fraction and the sign is the MSB.
module fpc_classify #(
    parameter int EXP_W  = fpc_pkg::EXP_W,
    parameter int FRAC_W = fpc_pkg::FRAC_W,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input  logic [DATA_W-1:0]  op,
    output fpc_pkg::fp_class_t cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_full;
    logic              frac_any;

    // Purpose: split the fields and derive the class bits
    always_comb begin
        exp_f    = op[FRAC_W +: EXP_W];
        frac_f   = op[FRAC_W-1:0];
        exp_full = &exp_f;
        frac_any = |frac_f;
        cls.nan  = exp_full & frac_any;
        cls.snan = exp_full & frac_any & ~frac_f[FRAC_W-1];
        cls.inf  = exp_full & ~frac_any;
        cls.zero = ~|op[DATA_W-2:0];
    end
endmodule

// File: rtl/fpc_order.sv
// Module: fpc_order
// Orders two non-NaN operands by sign and magnitude.
// Assumes the caller masks NaN cases; both zeros are equal regardless of sign.
module fpc_order #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              lt,
    output logic              eq
);
    localparam int MAG_W = DATA_W - 1;

    logic [MAG_W-1:0] mag_a;
    logic [MAG_W-1:0] mag_b;
    logic             sign_a;
    logic             sign_b;
    logic             mag_lt;

    // Purpose: sign-magnitude ordering with inverted sense for two negatives
    always_comb begin
        mag_a  = a[MAG_W-1:0];
        mag_b  = b[MAG_W-1:0];
        sign_a = a[DATA_W-1];
        sign_b = b[DATA_W-1];
        mag_lt = mag_a < mag_b;
        lt     = 1'b0;
        eq     = 1'b0;
        if ((mag_a == '0) && (mag_b == '0)) begin
            eq = 1'b1;
        end else if (sign_a != sign_b) begin
            lt = sign_a;
        end else if (mag_a == mag_b) begin
            eq = 1'b1;
        end else begin
            lt = sign_a ? ~mag_lt : mag_lt;
        end
    end
endmodule

// File: rtl/fpc_flag_reg.sv
// Module: fpc_flag_reg
// Holds the condition flags, the update strobe and the sticky invalid flag.
// Assumes inv_hit is only meaningful while req_valid is high; a set wins over a clear.
module fpc_flag_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [3:0] cc_next,
    input  logic       inv_hit,
    input  logic       clr_invalid,
    output logic [3:0] flags_q,
    output logic       vld_q,
    output logic       inv_q
);
    // Purpose: capture flags on a request and pulse the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= fpc_pkg::CC_NONE;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= req_valid;
            if (req_valid) begin
                flags_q <= cc_next;
            end
        end
    end

    // Purpose: sticky invalid flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q <= 1'b0;
        end else if (req_valid && inv_hit) begin
            inv_q <= 1'b1;
        end else if (clr_invalid) begin
            inv_q <= 1'b0;
        end
    end
endmodule

// File: rtl/fp_cmp_unit.sv
// Module: fp_cmp_unit
// Top of the single-precision compare unit: picks the second operand
// (register or +0), classifies both, orders them, encodes NZCV and
// registers the result. Assumes inputs are sampled on the rising edge.
module fp_cmp_unit #(
    parameter int EXP_W  = fpc_pkg::EXP_W,
    parameter int FRAC_W = fpc_pkg::FRAC_W,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_signaling,
    input  logic              req_zero_b,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              clr_invalid,
    output logic [3:0]        flags_o,
    output logic              flags_vld_o,
    output logic              invalid_o
);
    localparam int N_OPS = 2;

    logic [DATA_W-1:0]  ops [N_OPS];
    fpc_pkg::fp_class_t cls [N_OPS];
    logic               ord_lt;
    logic               ord_eq;
    logic               unordered;
    logic               any_snan;
    logic               inv_hit;
    fpc_pkg::cc_e       cc_next;

    // Purpose: route operand B or the positive zero constant
    always_comb begin
        ops[0] = op_a;
        ops[1] = req_zero_b ? '0 : op_b;
    end

    // One classifier per operand
    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        fpc_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_cls (
            .op  (ops[gi]),
            .cls (cls[gi])
        );
    end

    fpc_order #(
        .DATA_W (DATA_W)
    ) u_order (
        .a  (ops[0]),
        .b  (ops[1]),
        .lt (ord_lt),
        .eq (ord_eq)
    );

    // Purpose: combine classes and ordering into a condition code and invalid hit
    always_comb begin
        unordered = cls[0].nan | cls[1].nan;
        any_snan  = cls[0].snan | cls[1].snan;
        inv_hit   = req_signaling ? unordered : any_snan;
        if (unordered) begin
            cc_next = fpc_pkg::CC_UN;
        end else if (ord_eq) begin
            cc_next = fpc_pkg::CC_EQ;
        end else if (ord_lt) begin
            cc_next = fpc_pkg::CC_LT;
        end else begin
            cc_next = fpc_pkg::CC_GT;
        end
    end

    fpc_flag_reg u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .cc_next     (cc_next),
        .inv_hit     (inv_hit),
        .clr_invalid (clr_invalid),
        .flags_q     (flags_o),
        .vld_q       (flags_vld_o),
        .inv_q       (invalid_o)
    );
endmodule

// File: rtl/fp_cmp_unit_chk.sv
// Module: fp_cmp_unit_chk
// Port-level checker for fp_cmp_unit, attached by bind below.
module fp_cmp_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_signaling,
    input logic              req_zero_b,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              clr_invalid,
    input logic [3:0]        flags_o,
    input logic              flags_vld_o,
    input logic              invalid_o
);
    localparam int FW = fpc_pkg::FRAC_W;

    logic a_nan, b_nan, a_snan, b_snan, any_nan, any_snan;

    // Purpose: NaN kind of each port operand, zero substitution applied
    always_comb begin
        a_nan    = (&op_a[DATA_W-2:FW]) & (|op_a[FW-1:0]);
        a_snan   = a_nan & ~op_a[FW-1];
        b_nan    = ~req_zero_b & (&op_b[DATA_W-2:FW]) & (|op_b[FW-1:0]);
        b_snan   = b_nan & ~op_b[FW-1];
        any_nan  = a_nan | b_nan;
        any_snan = a_snan | b_snan;
    end

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        flags_vld_o |-> (flags_o inside {4'b1000, 4'b0110, 4'b0010, 4'b0011})); // R3
    AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && any_nan) |=> (flags_o == 4'b0011)); // R2
    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> flags_vld_o); // R8
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!flags_vld_o && $stable(flags_o))); // R8
    AST_QUIET_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_signaling && !any_snan && !invalid_o) |=> !invalid_o); // R5
    AST_QUIET_SNAN_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_signaling && any_snan) |=> invalid_o); // R5
    AST_SIGNAL_NAN_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_signaling && any_nan) |=> invalid_o); // R6
    AST_INV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_o && !clr_invalid) |=> invalid_o); // R9
    AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_invalid && !req_valid) |=> !invalid_o); // R9
endmodule

bind fp_cmp_unit fp_cmp_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_signaling (req_signaling),
    .req_zero_b    (req_zero_b),
    .op_a          (op_a),
    .op_b          (op_b),
    .clr_invalid   (clr_invalid),
    .flags_o       (flags_o),
    .flags_vld_o   (flags_vld_o),
    .invalid_o     (invalid_o)
);

// File: tb/fp_cmp_unit_tb.sv
module fp_cmp_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_signaling = 1'b0;
    logic        req_zero_b = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        clr_invalid = 1'b0;
    logic [3:0]  flags_o;
    logic        flags_vld_o;
    logic        invalid_o;

    int checks = 0;
    int errors = 0;
    logic exp_inv = 1'b0;

    localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
    localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
    localparam logic [31:0] QN = 32'h7FC0_0000, SN = 32'h7F80_0001;
    localparam logic [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000;
    localparam logic [31:0] MONE = 32'hBF80_0000, MTWO = 32'hC000_0000;

    always #5 clk = ~clk;

    fp_cmp_unit u_dut (.*);

    function automatic logic f_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction
    function automatic logic f_snan(input logic [31:0] x);
        return f_nan(x) && !x[22];
    endfunction
    function automatic logic [3:0] f_flags(input logic [31:0] a, input logic [31:0] b);
        logic neg_a, neg_b, less;
        if (f_nan(a) || f_nan(b)) return 4'b0011;
        if (a[30:0] == 0 && b[30:0] == 0) return 4'b0110;
        if (a == b) return 4'b0110;
        neg_a = a[31]; neg_b = b[31];
        if (neg_a != neg_b) less = neg_a;
        else if (!neg_a) less = a[30:0] < b[30:0];
        else less = a[30:0] > b[30:0];
        return less ? 4'b1000 : 4'b0010;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One request; results sampled at the following falling edge
    task automatic do_cmp(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic sig, input logic zb, input logic clr);
        logic [31:0] bb;
        logic hit;
        bb = zb ? PZ : b;
        hit = sig ? (f_nan(a) || f_nan(bb)) : (f_snan(a) || f_snan(bb));
        op_a = a; op_b = b; req_signaling = sig; req_zero_b = zb;
        req_valid = 1'b1; clr_invalid = clr;
        @(negedge clk);
        req_valid = 1'b0; clr_invalid = 1'b0;
        if (hit) exp_inv = 1'b1; else if (clr) exp_inv = 1'b0;
        check(req, {28'd0, flags_o}, {28'd0, f_flags(a, bb)});
        check("R8", {31'd0, flags_vld_o}, 32'd1);
        check(req, {31'd0, invalid_o}, {31'd0, exp_inv});
    endtask

    task automatic do_clear();
        clr_invalid = 1'b1;
        @(negedge clk);
        clr_invalid = 1'b0;
        exp_inv = 1'b0;
        check("R9", {31'd0, invalid_o}, 32'd0);
    endtask

    function automatic logic [31:0] pick_op();
        logic [31:0] r;
        r = $urandom;
        case ($urandom_range(0, 7))
            0: return {r[31], 8'hFF, 1'b1, r[21:0]};
            1: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
            2: return {r[31], 8'hFF, 23'd0};
            3: return {r[31], 31'd0};
            4: return {r[31], 8'h7F, r[22:0]};
            default: return {r[31], (r[30:23] == 8'hFF) ? 8'hFE : r[30:23], r[22:0]};
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R10", {28'd0, flags_o}, 32'd0);
        check("R10", {31'd0, flags_vld_o}, 32'd0);
        check("R10", {31'd0, invalid_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        do_cmp("R3", ONE, TWO, 0, 0, 0);
        do_cmp("R3", TWO, ONE, 0, 0, 0);
        do_cmp("R3", ONE, ONE, 0, 0, 0);
        do_cmp("R4", PZ, NZ, 0, 0, 0);
        do_cmp("R4", MTWO, MONE, 0, 0, 0);
        do_cmp("R4", PINF, PINF, 0, 0, 0);
        do_cmp("R4", NINF, MTWO, 0, 0, 0);
        do_cmp("R4", PINF, TWO, 1, 0, 0);
        do_cmp("R5", QN, ONE, 0, 0, 0);
        do_cmp("R2", ONE, QN, 0, 0, 0);
        do_cmp("R1", 32'h7FFF_FFFF, ONE, 0, 0, 0);
        do_cmp("R5", SN, ONE, 0, 0, 0);
        do_cmp("R9", ONE, TWO, 0, 0, 0);
        @(negedge clk);
        check("R8", {31'd0, flags_vld_o}, 32'd0);
        check("R8", {28'd0, flags_o}, 32'h8);
        check("R9", {31'd0, invalid_o}, 32'd1);
        do_clear();
        do_cmp("R6", ONE, QN, 1, 0, 0);
        do_clear();
        do_cmp("R7", MONE, SN, 1, 1, 0);
        do_cmp("R7", PZ, QN, 1, 1, 0);
        do_cmp("R7", ONE, MTWO, 0, 1, 0);
        do_cmp("R9", QN, PZ, 1, 0, 1);
        do_cmp("R9", ONE, ONE, 0, 0, 1);

        for (int i = 0; i < 3000; i++) begin
            do_cmp("R2", pick_op(), pick_op(), 1'($urandom_range(0, 1)),
                   ($urandom_range(0, 5) == 0), ($urandom_range(0, 7) == 0));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule